// File: doc/BRIEF.md
# Core-Local Interrupt Register Bank

This block is the software-visible state of a core-local interrupt controller. A byte-wide read/write bus port reaches a small global area and one four-byte slot for each interrupt source. The global area holds a configuration byte carrying the level-width field, a read-only information word describing the build, and a threshold byte. Each slot holds a pending flag, an enable flag, an attribute byte (vector select and trigger mode) and a control byte (level and priority).

Each raw interrupt line passes through a two-stage synchroniser. The trigger mode of its source then turns it into a pending flag. A level source mirrors its line. A rising-edge or falling-edge source latches the event, and the flag stays set until software clears it or the downstream arbiter acknowledges it. All per-source state and the global fields are driven out in parallel to the arbiter, which is not part of this block.

Top module: `irq_regbank`

## Requirements
- R1: After reset every register reads zero, except that the unimplemented low bits of each control byte read as ones. All pending, enable, vector and trigger outputs are zero.
- R2: The configuration byte is at offset 0x000, and its level-width field sits in bits 4:1 with bits 0 and 7:5 reading zero. The threshold byte is at offset 0x00B and keeps all 8 bits. Their values drive `nlbits_o` and `thresh_o`.
- R3: Offsets 0x004 to 0x007 return, low byte first, a 32-bit word. Bits 12:0 hold the source count, bits 20:13 the version, bits 24:21 the implemented control-bit count, and bits 31:25 read zero. Writes there are ignored.
- R4: Source i owns offsets 0x1000+4*i to 0x1000+4*i+3. The bytes are pending (bit 0), enable (bit 0), attribute (bit 0 vector select, bits 2:1 trigger mode) and control. All other bits of the first three bytes read zero.
- R5: The control byte stores only its top CTL_BITS bits. The lower bits read as ones and ignore writes.
- R6: When trigger bit 0 is 0 the source is level-triggered. Its pending flag equals the raw line as it was three clock edges earlier, and software writes to the pending byte have no lasting effect.
- R7: With trigger mode 01, a rising edge of the line sets pending three edges after the change. Pending stays set after the line falls.
- R8: With trigger mode 11, a falling edge sets pending in the same way, and a rising edge does not.
- R9: For an edge-triggered source, a write to the pending byte loads its bit 0, so software can both set and clear the flag.
- R10: A one-cycle pulse on `ack_i[i]` clears the pending flag of an edge-triggered source i. An edge detected in the same cycle takes precedence, then a software write, then the acknowledge.
- R11: Reads of unmapped offsets, including slots at or beyond the source count, return zero. Writes to them change no state.
- R12: Read data appears on `rdata_o` on the clock edge that accepts the read, and it holds its value until the next read.
- R13: `en_o`, `shv_o`, `trig_o` and `ctl_o` present the current per-source enable, vector select, trigger mode and full control byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte offset |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, registered |
| irq_i | input | NUM_SRC | Raw interrupt lines |
| ack_i | input | NUM_SRC | Arbiter acknowledge, one per source |
| pend_o | output | NUM_SRC | Pending flags |
| en_o | output | NUM_SRC | Enable flags |
| shv_o | output | NUM_SRC | Vector-mode selects |
| trig_o | output | 2*NUM_SRC | Trigger modes, source i in bits 2i+1:2i |
| ctl_o | output | 8*NUM_SRC | Control bytes, source i in bits 8i+7:8i |
| nlbits_o | output | 4 | Level-width field |
| thresh_o | output | 8 | Threshold byte |

## Verification
The assertions check several properties on every cycle. An edge-mode pending flag never drops without a software write or an acknowledge, and an acknowledge with no competing event always clears it. Read data holds while no read is accepted. Reads of unmapped or reserved bits come back zero. The synchroniser latency, each trigger mode's response to both edge directions, control-bit masking, the information word and the address map can only be shown by the bench's directed scenarios, which drive lines and bus cycles and compare against values worked out from the requirements.

// File: rtl/irq_regbank_pkg.sv
package irq_regbank_pkg;
  localparam int unsigned OFS_CFG   = 'h000;
  localparam int unsigned OFS_THR   = 'h00B;
  localparam int unsigned INFO_WORD = 'h001;  // addr >> 2 for the info word
  localparam int unsigned SRC_BASE  = 'h1000;

  typedef enum logic [1:0] {
    SEL_PEND = 2'd0,
    SEL_EN   = 2'd1,
    SEL_ATTR = 2'd2,
    SEL_CTL  = 2'd3
  } slot_sel_e;

  function automatic logic edge_mode(input logic [1:0] trig);
    return trig[0];
  endfunction
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/irq_src_cell.sv
module irq_src_cell
  import irq_regbank_pkg::*;
#(
  parameter int unsigned CTL_BITS = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sync_i,
  input  logic                ack_i,
  input  logic                wr_pend_i,
  input  logic                wr_en_i,
  input  logic                wr_attr_i,
  input  logic                wr_ctl_i,
  input  logic                bit0_i,
  input  logic [2:0]          attr_wd_i,
  input  logic [CTL_BITS-1:0] ctl_wd_i,
  output logic                pend_o,
  output logic                en_o,
  output logic                shv_o,
  output logic [1:0]          trig_o,
  output logic [7:0]          ctl_o
);
  localparam int unsigned LOW_BITS = 8 - CTL_BITS;

  logic                pend_q, en_q, shv_q, prev_q;
  logic [1:0]          trig_q;
  logic [CTL_BITS-1:0] ctl_q;
  logic                edge_hit;

  // trig[1] picks polarity once trig[0] selects edge capture
  assign edge_hit = trig_q[1] ? (prev_q & ~sync_i) : (sync_i & ~prev_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      en_q   <= 1'b0;
      shv_q  <= 1'b0;
      trig_q <= 2'b00;
      ctl_q  <= '0;
      prev_q <= 1'b0;
    end else begin
      prev_q <= sync_i;
      if (wr_en_i)   en_q <= bit0_i;
      if (wr_attr_i) {trig_q, shv_q} <= attr_wd_i;
      if (wr_ctl_i)  ctl_q <= ctl_wd_i;
      if (!edge_mode(trig_q))  pend_q <= sync_i;
      else if (edge_hit)       pend_q <= 1'b1;
      else if (wr_pend_i)      pend_q <= bit0_i;
      else if (ack_i)          pend_q <= 1'b0;
    end
  end

  generate
    if (LOW_BITS > 0) begin : g_pad
      assign ctl_o = {ctl_q, {LOW_BITS{1'b1}}};
    end else begin : g_full
      assign ctl_o = ctl_q;
    end
  endgenerate

  assign pend_o = pend_q;
  assign en_o   = en_q;
  assign shv_o  = shv_q;
  assign trig_o = trig_q;

  p_edge_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_q[0] && pend_q && !wr_pend_i && !ack_i) |=> pend_q);

  p_ack_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_q[0] && ack_i && !wr_pend_i && !edge_hit) |=> !pend_q);
endmodule

// File: rtl/irq_regbank.sv
module irq_regbank
  import irq_regbank_pkg::*;
#(
  parameter int unsigned NUM_SRC  = 32,
  parameter int unsigned CTL_BITS = 4,
  parameter int unsigned ADDR_W   = 16,
  parameter logic [7:0]  VERSION  = 8'h21
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_i,
  input  logic                  we_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [7:0]            wdata_i,
  output logic [7:0]            rdata_o,
  input  logic [NUM_SRC-1:0]    irq_i,
  input  logic [NUM_SRC-1:0]    ack_i,
  output logic [NUM_SRC-1:0]    pend_o,
  output logic [NUM_SRC-1:0]    en_o,
  output logic [NUM_SRC-1:0]    shv_o,
  output logic [2*NUM_SRC-1:0]  trig_o,
  output logic [8*NUM_SRC-1:0]  ctl_o,
  output logic [3:0]            nlbits_o,
  output logic [7:0]            thresh_o
);
  localparam int unsigned IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam int unsigned SLOT_W = ADDR_W - 2;
  localparam logic [31:0] INFO_VAL =
    {7'd0, 4'(CTL_BITS), VERSION, 13'(NUM_SRC)};

  logic [NUM_SRC-1:0] sync;
  logic [3:0]         nlbits_q;
  logic [7:0]         thr_q;
  logic [7:0]         rd_mux;
  logic [ADDR_W-1:0]  src_ofs;
  logic [SLOT_W-1:0]  slot;
  logic [IDX_W-1:0]   idx;
  logic               src_hit, wr, rd, map_hit;
  slot_sel_e          sel;

  logic [7:0] ctl_arr  [NUM_SRC];
  logic [1:0] trig_arr [NUM_SRC];

  assign wr      = req_i && we_i;
  assign rd      = req_i && !we_i;
  assign src_ofs = addr_i - ADDR_W'(SRC_BASE);
  assign slot    = src_ofs[ADDR_W-1:2];
  assign idx     = slot[IDX_W-1:0];
  assign sel     = slot_sel_e'(src_ofs[1:0]);
  assign src_hit = (addr_i >= ADDR_W'(SRC_BASE)) && (slot < SLOT_W'(NUM_SRC));

  irq_sync #(.W(NUM_SRC)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (irq_i),
    .q_o    (sync)
  );

  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      logic hit_i;
      assign hit_i = wr && src_hit && (idx == IDX_W'(i));
      irq_src_cell #(.CTL_BITS(CTL_BITS)) i_cell (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .sync_i    (sync[i]),
        .ack_i     (ack_i[i]),
        .wr_pend_i (hit_i && sel == SEL_PEND),
        .wr_en_i   (hit_i && sel == SEL_EN),
        .wr_attr_i (hit_i && sel == SEL_ATTR),
        .wr_ctl_i  (hit_i && sel == SEL_CTL),
        .bit0_i    (wdata_i[0]),
        .attr_wd_i (wdata_i[2:0]),
        .ctl_wd_i  (wdata_i[7 -: CTL_BITS]),
        .pend_o    (pend_o[i]),
        .en_o      (en_o[i]),
        .shv_o     (shv_o[i]),
        .trig_o    (trig_arr[i]),
        .ctl_o     (ctl_arr[i])
      );
      assign trig_o[2*i +: 2] = trig_arr[i];
      assign ctl_o[8*i +: 8]  = ctl_arr[i];
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nlbits_q <= '0;
      thr_q    <= '0;
    end else if (wr) begin
      if (addr_i == ADDR_W'(OFS_CFG)) nlbits_q <= wdata_i[4:1];
      if (addr_i == ADDR_W'(OFS_THR)) thr_q    <= wdata_i;
    end
  end

  always_comb begin
    rd_mux  = 8'h00;
    map_hit = 1'b1;
    if (addr_i == ADDR_W'(OFS_CFG)) begin
      rd_mux = {3'b000, nlbits_q, 1'b0};
    end else if (addr_i[ADDR_W-1:2] == SLOT_W'(INFO_WORD)) begin
      rd_mux = INFO_VAL[8*addr_i[1:0] +: 8];
    end else if (addr_i == ADDR_W'(OFS_THR)) begin
      rd_mux = thr_q;
    end else if (src_hit) begin
      unique case (sel)
        SEL_PEND: rd_mux = {7'd0, pend_o[idx]};
        SEL_EN:   rd_mux = {7'd0, en_o[idx]};
        SEL_ATTR: rd_mux = {5'd0, trig_arr[idx], shv_o[idx]};
        SEL_CTL:  rd_mux = ctl_arr[idx];
        default:  rd_mux = 8'h00;
      endcase
    end else begin
      map_hit = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_o <= 8'h00;
    else if (rd)  rdata_o <= rd_mux;
  end

  assign nlbits_o = nlbits_q;
  assign thresh_o = thr_q;

  p_unmapped_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && !map_hit) |=> (rdata_o == 8'h00));

  p_cfg_reserved_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && addr_i == ADDR_W'(OFS_CFG)) |=> (rdata_o[0] == 1'b0 && rdata_o[7:5] == 3'b000));

  p_rdata_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |=> $stable(rdata_o));
endmodule

// File: tb/test_irq_regbank.sv
module test_irq_regbank;
  localparam int unsigned N  = 32;
  localparam int unsigned AW = 16;
  localparam int unsigned S  = 3;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_i = 1'b0, we_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [7:0]    wdata_i = '0;
  logic [7:0]    rdata_o;
  logic [N-1:0]  irq_i = '0, ack_i = '0;
  logic [N-1:0]  pend_o, en_o, shv_o;
  logic [2*N-1:0] trig_o;
  logic [8*N-1:0] ctl_o;
  logic [3:0]    nlbits_o;
  logic [7:0]    thresh_o;

  int checks = 0;
  int errors = 0;

  always #5 clk_i = ~clk_i;

  irq_regbank i_irq_regbank (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .irq_i(irq_i), .ack_i(ack_i), .pend_o(pend_o), .en_o(en_o),
    .shv_o(shv_o), .trig_o(trig_o), .ctl_o(ctl_o),
    .nlbits_o(nlbits_o), .thresh_o(thresh_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic bus_rd(input logic [AW-1:0] a, output logic [7:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    @(negedge clk_i);
    req_i = 1'b0;
    d = rdata_o;
  endtask

  function automatic logic [AW-1:0] src_a(input int i, input int b);
    return AW'(32'h1000 + 4 * i + b);
  endfunction

  task automatic edges(input int n);
    repeat (n) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    check("R1 pend_o", pend_o, '0);
    check("R1 en_o", en_o, '0);
    check("R1 trig_o", trig_o[31:0], '0);
    bus_rd(src_a(S, 3), d); check("R1 ctl reset", d, 8'h0F);
    bus_rd(16'h000B, d);    check("R1 thresh reset", d, 8'h00);
  endtask

  task automatic t_globals;
    logic [7:0] d;
    bus_wr(16'h0000, 8'hFF);
    bus_rd(16'h0000, d); check("R2 cfg readback", d, 8'h1E);
    check("R2 nlbits_o", nlbits_o, 4'hF);
    bus_wr(16'h000B, 8'h5A);
    bus_rd(16'h000B, d); check("R2 thresh readback", d, 8'h5A);
    check("R2 thresh_o", thresh_o, 8'h5A);
  endtask

  task automatic t_info;
    logic [7:0] d;
    bus_wr(16'h0004, 8'hFF);
    bus_rd(16'h0004, d); check("R3 info byte0", d, 8'h20);
    bus_rd(16'h0005, d); check("R3 info byte1", d, 8'h20);
    bus_rd(16'h0006, d); check("R3 info byte2", d, 8'h84);
    bus_rd(16'h0007, d); check("R3 info byte3", d, 8'h00);
  endtask

  task automatic t_src_regs;
    logic [7:0] d;
    bus_wr(src_a(S, 1), 8'hFF);
    bus_rd(src_a(S, 1), d); check("R4 enable byte", d, 8'h01);
    check("R13 en_o", en_o[S], 1'b1);
    bus_wr(src_a(S, 2), 8'hF9);
    bus_rd(src_a(S, 2), d); check("R4 attr byte", d, 8'h01);
    check("R13 shv_o", shv_o[S], 1'b1);
    check("R13 trig_o", trig_o[2*S +: 2], 2'b00);
  endtask

  task automatic t_ctl;
    logic [7:0] d;
    bus_wr(src_a(S, 3), 8'hA0);
    bus_rd(src_a(S, 3), d); check("R5 ctl low ones", d, 8'hAF);
    check("R13 ctl_o", ctl_o[8*S +: 8], 8'hAF);
    bus_wr(src_a(S, 3), 8'h05);
    bus_rd(src_a(S, 3), d); check("R5 ctl low writes ignored", d, 8'h0F);
  endtask

  task automatic t_level;
    @(negedge clk_i); irq_i[S] = 1'b1;
    edges(2); check("R6 level before latency", pend_o[S], 1'b0);
    edges(1); check("R6 level after latency", pend_o[S], 1'b1);
    bus_wr(src_a(S, 0), 8'h00);
    check("R6 level sw write no effect", pend_o[S], 1'b1);
    irq_i[S] = 1'b0;
    edges(3); check("R6 level follows low", pend_o[S], 1'b0);
    bus_wr(src_a(S, 0), 8'h01);
    edges(1); check("R6 level sw set no lasting effect", pend_o[S], 1'b0);
  endtask

  task automatic t_rise;
    logic [7:0] d;
    bus_wr(src_a(S, 2), 8'h02);
    check("R7 trig_o rising", trig_o[2*S +: 2], 2'b01);
    @(negedge clk_i); irq_i[S] = 1'b1;
    edges(2); check("R7 rise before latency", pend_o[S], 1'b0);
    edges(1); check("R7 rise sets pend", pend_o[S], 1'b1);
    irq_i[S] = 1'b0;
    edges(5); check("R7 rise sticky", pend_o[S], 1'b1);
    bus_rd(src_a(S, 0), d); check("R4 pend byte", d, 8'h01);
  endtask

  task automatic t_soft;
    bus_wr(src_a(S, 0), 8'hFE);
    check("R9 sw clear", pend_o[S], 1'b0);
    bus_wr(src_a(S, 0), 8'h01);
    check("R9 sw set", pend_o[S], 1'b1);
    edges(3); check("R9 sw set holds", pend_o[S], 1'b1);
  endtask

  task automatic t_ack;
    @(negedge clk_i); ack_i[S] = 1'b1;
    @(negedge clk_i); ack_i[S] = 1'b0;
    check("R10 ack clears", pend_o[S], 1'b0);
  endtask

  task automatic t_fall;
    bus_wr(src_a(S, 2), 8'h06);
    check("R8 trig_o falling", trig_o[2*S +: 2], 2'b11);
    @(negedge clk_i); irq_i[S] = 1'b1;
    edges(5); check("R8 rising ignored", pend_o[S], 1'b0);
    irq_i[S] = 1'b0;
    edges(2); check("R8 fall before latency", pend_o[S], 1'b0);
    edges(1); check("R8 fall sets pend", pend_o[S], 1'b1);
  endtask

  task automatic t_unmapped;
    logic [7:0] d;
    bus_rd(16'h0008, d); check("R11 reserved read", d, 8'h00);
    bus_wr(src_a(N, 1), 8'hFF);
    bus_wr(src_a(N, 3), 8'hFF);
    bus_rd(src_a(N, 1), d); check("R11 out of range read", d, 8'h00);
    check("R11 no alias enable", en_o[0], 1'b0);
    bus_rd(src_a(0, 3), d); check("R11 no alias ctl", d, 8'h0F);
  endtask

  task automatic t_rdata_hold;
    logic [7:0] d;
    bus_rd(16'h000B, d);
    bus_wr(16'h000B, 8'h33);
    edges(3); check("R12 rdata holds", rdata_o, 8'h5A);
    bus_rd(16'h000B, d); check("R12 new read", d, 8'h33);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i); rst_ni = 1'b1;
    t_reset();
    t_globals();
    t_info();
    t_src_regs();
    t_ctl();
    t_level();
    t_rise();
    t_soft();
    t_ack();
    t_fall();
    t_unmapped();
    t_rdata_hold();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule